// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This controller collects interrupt requests from six internal peripheral sources: one watchdog, two timers, one bus controller and two serial ports. It registers each request into a pending bit and holds a mask bit for every source. Each source also has a control register that holds a level, a priority within that level and an autovector flag. The controller drives the level of the best pending, unmasked request to the processor core. Some control fields are fixed by the source class. The watchdog always sits at level 7 and always supplies a vector of its own. The timers and the bus controller always autovector. The serial ports choose between an autovector and a vector that the serial module supplies.

When the core runs an acknowledge cycle, it presents the level it is serving. In the same cycle the controller answers with the winning source as a one-hot code, so that source can withdraw its request. It also answers with either a vector number or an autovector flag. Registers are reached through a plain write-strobe and address port. Reads are combinational.

Source index map: 0 = watchdog, 1 and 2 = timers, 3 = bus controller, 4 and 5 = serial ports. Register addresses:
- 0 to 5: control register of that source, with bits [2:0] = level, bits [4:3] = priority and bit 5 = autovector.
- 6: mask register, bits [5:0], where 1 = masked.
- 7: pending register, bits [5:0], read only.
- 8: watchdog vector register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `ipl_o` is 0 and every control register reads its forced fields over zeros. The mask register (address 6) reads 0x3F, the pending register (address 7) reads 0x00 and the watchdog vector (address 8) reads 0x0F.
- R2: Pending bit i reads as the value `irq_req[i]` had at the previous rising clock edge, whether or not bit i is masked.
- R3: `ipl_o` equals the level of the winning source among those that are pending, unmasked and at a nonzero level. It is 0 when no source qualifies.
- R4: The winner is the source with the highest level. A tie is broken by the higher 2-bit priority. A remaining tie goes to the lowest source index.
- R5: The watchdog control register always reads level 7 and autovector 0, and writes to those fields are ignored. When the watchdog is acknowledged, `ack_auto_o` is 0 and `ack_vec_o` equals the watchdog vector register.
- R6: Sources 1, 2 and 3 always read autovector 1, and a write of 0 to that bit is ignored. When one of them is acknowledged, `ack_auto_o` is 1 and `ack_vec_o` is 0.
- R7: The serial sources (4 and 5) keep the autovector bit as written. When that bit is 0 and the source is acknowledged, `ack_vec_o` is `ser_vec0` for source 4 and `ser_vec1` for source 5. When the bit is 1, `ack_auto_o` is 1 and `ack_vec_o` is 0.
- R8: When `ack_i` is high and `ack_lvl_i` equals a nonzero `ipl_o`, `ack_src_o` is the one-hot code of the winner in the same cycle. Otherwise `ack_src_o`, `ack_auto_o` and `ack_vec_o` are all 0.
- R9: A masked source never drives `ipl_o` and is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational register read data |
| irq_req | input | 6 | Request lines, one per source |
| ser_vec0 | input | VW | Vector supplied by serial source 4 |
| ser_vec1 | input | VW | Vector supplied by serial source 5 |
| ipl_o | output | 3 | Level presented to the core |
| ack_i | input | 1 | Acknowledge cycle active |
| ack_lvl_i | input | 3 | Level being acknowledged |
| ack_src_o | output | 6 | One-hot code of the acknowledged source |
| ack_auto_o | output | 1 | Acknowledge answered with an autovector |
| ack_vec_o | output | VW | Vector number for a vectored acknowledge |

## Verification
The bench sets up a mix of sources. Two timers share the same level and priority, so a wrong tie-break would pick source 2 instead of source 1. A bus source and a serial source share a level, so a design that compared only levels would pick the bus source instead of the serial one. The bench then applies masks to show that a masked watchdog gives way to the next source down, and it checks that the pending bits still follow masked requests. It writes illegal values into the forced fields; a design that stored those values would report a watchdog below level 7, or a timer without an autovector. Further tests cover an acknowledge at the wrong level, a serial source switched to autovector, and a rewritten watchdog vector, each of which exposes a design that returned a stale or wrong vector.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [5:0]    irq_req,
  input  logic [VW-1:0] ser_vec0,
  input  logic [VW-1:0] ser_vec1,
  output logic [2:0]    ipl_o,
  input  logic          ack_i,
  input  logic [2:0]    ack_lvl_i,
  output logic [5:0]    ack_src_o,
  output logic          ack_auto_o,
  output logic [VW-1:0] ack_vec_o
);
  localparam int NSRC = 6;

  logic [2:0]    lvl_q [NSRC];
  logic [1:0]    pri_q [NSRC];
  logic [NSRC-1:0] av_q, mask_q, pend_q;
  logic [VW-1:0] wdvec_q;

  logic [2:0]    lvl_e [NSRC];
  logic [NSRC-1:0] av_e, act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        lvl_q[i] <= '0;
        pri_q[i] <= '0;
      end
      av_q    <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
      wdvec_q <= VW'(8'h0F);
    end else begin
      pend_q <= irq_req;
      if (reg_we) begin
        for (int i = 0; i < NSRC; i++)
          if (reg_addr == 4'(i)) begin
            lvl_q[i] <= reg_wdata[2:0];
            pri_q[i] <= reg_wdata[4:3];
            av_q[i]  <= reg_wdata[5];
          end
        if (reg_addr == 4'd6) mask_q  <= reg_wdata[NSRC-1:0];
        if (reg_addr == 4'd8) wdvec_q <= VW'(reg_wdata);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      lvl_e[i] = (i == 0) ? 3'd7 : lvl_q[i];
      av_e[i]  = (i == 0) ? 1'b0 : (i < 4) ? 1'b1 : av_q[i];
      act[i]   = pend_q[i] && !mask_q[i] && (lvl_e[i] != 3'd0);
    end
  end

  logic       found;
  logic [4:0] best_key;
  logic [2:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i] && (!found || {lvl_e[i], pri_q[i]} > best_key)) begin
        found    = 1'b1;
        best_key = {lvl_e[i], pri_q[i]};
        best_idx = 3'(i);
      end
  end

  assign ipl_o = found ? best_key[4:2] : 3'd0;

  logic hit;
  assign hit        = ack_i && found && (ack_lvl_i == best_key[4:2]);
  assign ack_src_o  = hit ? NSRC'(1) << best_idx : '0;
  assign ack_auto_o = hit && av_e[best_idx];
  assign ack_vec_o  = (!hit || av_e[best_idx]) ? '0 :
                      (best_idx == 3'd0) ? wdvec_q :
                      (best_idx == 3'd4) ? ser_vec0 : ser_vec1;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == 4'(i)) reg_rdata = {2'b00, av_e[i], pri_q[i], lvl_e[i]};
    if (reg_addr == 4'd6) reg_rdata = {2'b00, mask_q};
    if (reg_addr == 4'd7) reg_rdata = {2'b00, pend_q};
    if (reg_addr == 4'd8) reg_rdata = 8'(wdvec_q);
  end

  AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_q == $past(irq_req)); // R2
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_src_o)); // R8
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_src_o != '0) |-> (ack_i && ack_lvl_i == ipl_o && ipl_o != 3'd0)); // R8
  AST_NO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_src_o & mask_q) == '0); // R9
  AST_FIXED_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_src_o[3:1] != '0) |-> (ack_auto_o && ack_vec_o == '0)); // R6
  AST_WD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_src_o[0] |-> (!ack_auto_o && ack_vec_o == wdvec_q && ipl_o == 3'd7)); // R5
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 0, rst_n = 0, reg_we = 0, ack_i = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, ack_vec_o;
  logic [5:0] irq_req = 0, ack_src_o;
  logic [2:0] ipl_o, ack_lvl_i = 0;
  logic       ack_auto_o;
  logic [7:0] ser_vec0 = 8'h51, ser_vec1 = 8'h62;
  int checks = 0, errors = 0;
  logic [7:0] wdv = 8'h0F;
  logic       s4_auto = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.VW(8)) u_irq_prio_ctrl (.*);

  localparam int NV = 8;
  // {req, mask, expected ipl, expected one-hot winner}
  localparam logic [20:0] VECS [NV] = '{
    {6'b000110, 6'b000000, 3'd3, 6'b000010},
    {6'b011000, 6'b000000, 3'd5, 6'b010000},
    {6'b011000, 6'b010000, 3'd5, 6'b001000},
    {6'b111111, 6'b000000, 3'd7, 6'b000001},
    {6'b111111, 6'b000001, 3'd5, 6'b010000},
    {6'b100110, 6'b000110, 3'd2, 6'b100000},
    {6'b000000, 6'b000000, 3'd0, 6'b000000},
    {6'b111111, 6'b111111, 3'd0, 6'b000000}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [8:0] exp_ack(logic [5:0] src);
    case (src)
      6'b000001: return {1'b0, wdv};
      6'b000010, 6'b000100, 6'b001000: return {1'b1, 8'h00};
      6'b010000: return s4_auto ? {1'b1, 8'h00} : {1'b0, ser_vec0};
      6'b100000: return {1'b1, 8'h00};
      default:   return 9'h000;
    endcase
  endfunction

  task automatic do_ack(string tag, logic [2:0] lvl, logic [5:0] exp_src);
    logic [8:0] e;
    e = exp_ack(exp_src);
    @(negedge clk); ack_i = 1; ack_lvl_i = lvl; #1;
    chk({tag, " src"}, ack_src_o, exp_src);
    chk({tag, " auto"}, ack_auto_o, e[8]);
    chk({tag, " vec"}, ack_vec_o, e[7:0]);
    @(negedge clk); ack_i = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R1 ipl", ipl_o, 0);
    rd(4'd6, d); chk("R1 mask", d, 8'h3F);
    rd(4'd7, d); chk("R1 pend", d, 8'h00);
    rd(4'd8, d); chk("R1 wdvec", d, 8'h0F);
    rd(4'd1, d); chk("R1 timer ctrl", d, 8'h20);

    wr(4'd0, 8'h29); wr(4'd1, 8'h13); wr(4'd2, 8'h13);
    wr(4'd3, 8'h05); wr(4'd4, 8'h1D); wr(4'd5, 8'h22);
    rd(4'd0, d); chk("R5 wd ctrl", d, 8'h0F);
    rd(4'd1, d); chk("R6 timer ctrl", d, 8'h33);
    rd(4'd3, d); chk("R6 bus ctrl", d, 8'h25);
    rd(4'd4, d); chk("R7 serial ctrl", d, 8'h1D);
    rd(4'd5, d); chk("R7 serial ctrl", d, 8'h22);

    for (int i = 0; i < NV; i++) begin
      wr(4'd6, {2'b00, VECS[i][14:9]});
      @(negedge clk); irq_req = VECS[i][20:15];
      @(negedge clk);
      chk($sformatf("R3 R4 R9 ipl vec%0d", i), ipl_o, VECS[i][8:6]);
      rd(4'd7, d); chk($sformatf("R2 pend vec%0d", i), d, {2'b00, VECS[i][20:15]});
      do_ack($sformatf("R8 vec%0d", i), VECS[i][8:6], VECS[i][5:0]);
    end

    wr(4'd6, 8'h00);
    @(negedge clk); irq_req = 6'b000001;
    @(negedge clk);
    do_ack("R8 wrong level", 3'd6, 6'b000000);

    wr(4'd8, 8'h40); wdv = 8'h40;
    do_ack("R5 new wdvec", 3'd7, 6'b000001);

    @(negedge clk); irq_req = 6'b010000;
    wr(4'd4, 8'h3D); s4_auto = 1;
    do_ack("R7 serial auto", 3'd5, 6'b010000);

    @(negedge clk); irq_req = 6'b100000;
    wr(4'd5, 8'h02);
    @(negedge clk); ser_vec1 = 8'h77;
    begin
      @(negedge clk); ack_i = 1; ack_lvl_i = 3'd2; #1;
      chk("R7 serial1 vec", ack_vec_o, 8'h77);
      chk("R7 serial1 auto", ack_auto_o, 0);
      @(negedge clk); ack_i = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule